// File: doc/BRIEF.md
# Graphics Aperture Window Configuration

This block holds the configuration registers for a graphics address-remapping window. Software programs three things through a byte-wide configuration port: the window base, a control byte that selects the window size and carries two flag bits, and the base of the translation table. The block drives these settings out continuously as decoded values. They are the aligned window base, the window size in bytes, a feature flag and the table base. The table base is gated by its enable bit.

The window base is always kept aligned to the selected size. Any write to a base byte, a table byte or the control byte clears the base bits that lie below the window size, and those bits stay cleared in the stored register. A probe address input is compared against the window, and a hit output shows whether the address falls inside it. Walking the translation table and translating addresses are done elsewhere.

Top module: `gfx_aperture_cfg`

## Requirements
- R1: After reset every register reads 0x00. The window base, table base and flag outputs are 0, and the window size is 4 MB (32'h0040_0000), because size code 0 is selected.
- R2: Byte 0x13 holds base bits 31:24. Byte 0x12 holds base bits 23:22 in its bits 7:6, and its bits 5:0 read 0. Bytes 0x10 and 0x11 always read 0x00, and writes to them have no effect.
- R3: Bits 6:4 of control byte 0x94 are the size code. Codes 0 to 6 give a window size of 32'h0040_0000 shifted left by the code, which is 4 MB to 256 MB. Code 7 gives size 0, which disables the window.
- R4: A write to byte 0x94 keeps only the bits under mask 0x7F, so bit 7 always reads 0.
- R5: Bit 1 of byte 0x94 is driven out as `win_flag`.
- R6: Bytes 0x91, 0x92 and 0x93 hold table base bits 15:8, 23:16 and 31:24 and read back as written. When bit 0 of byte 0x94 is set, `tbl_base` shows these bytes with bits 7:0 at zero. When bit 0 is clear, `tbl_base` is 0.
- R7: A write to byte 0x12, 0x13, 0x91, 0x92, 0x93 or 0x94 realigns the stored base. Every base bit below the selected size is cleared, and the readback of bytes 0x12 and 0x13 shows the cleared bits. Cleared bits do not return when a smaller size is chosen later. With code 7, no bit is cleared.
- R8: `probe_hit` is 1 when `win_base <= probe_addr < win_base + win_size` and the size is nonzero. Otherwise it is 0.
- R9: Addresses outside the implemented set read 0x00, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr`, combinational |
| win_base | output | 32 | Aligned window base |
| win_size | output | 32 | Window size in bytes, 0 when disabled |
| win_flag | output | 1 | Feature flag, bit 1 of the control byte |
| tbl_base | output | 32 | Table base, or 0 when the table is disabled |
| probe_addr | input | 32 | Address to test against the window |
| probe_hit | output | 1 | Probe address lies inside the window |

## Verification
A table of write and readback pairs runs the base bytes through a sequence of sizes. The size-7 step shows that a disabled window leaves the base bits alone. The 8 MB step and the 256 MB step show that realignment happens on size writes and on base writes. Moving back to 4 MB shows that cleared bits stay cleared. Directed tests then sweep all eight size codes and toggle the flag and table-enable bits. They also probe addresses at the first byte, the last byte, one past the window and one below it, and at a disabled window, to tell an inclusive bound from an exclusive one.

// File: rtl/gfx_aperture_cfg.sv
module gfx_aperture_cfg #(
  parameter int AW      = 32,
  parameter int MIN_LOG = 22,
  parameter int NCODE   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_size,
  output logic          win_flag,
  output logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  localparam int BW = AW - MIN_LOG;

  logic [BW-1:0] base_q, base_n;
  logic [7:0]    ctrl_q, ctrl_n;
  logic [7:0]    t1_q, t2_q, t3_q;
  logic          grp_wr;

  function automatic logic [BW-1:0] amask(input logic [2:0] code);
    if (int'(code) >= NCODE) return '1;
    return {BW{1'b1}} << code;
  endfunction

  assign grp_wr = cfg_wr && (cfg_addr == 8'h12 || cfg_addr == 8'h13 ||
                             cfg_addr == 8'h91 || cfg_addr == 8'h92 ||
                             cfg_addr == 8'h93 || cfg_addr == 8'h94);

  always_comb begin
    base_n = base_q;
    ctrl_n = ctrl_q;
    if (cfg_wr && cfg_addr == 8'h12) base_n[1:0]  = cfg_wdata[7:6];
    if (cfg_wr && cfg_addr == 8'h13) base_n[BW-1:2] = cfg_wdata[BW-3:0];
    if (cfg_wr && cfg_addr == 8'h94) ctrl_n = cfg_wdata & 8'h7f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      t3_q   <= '0;
    end else begin
      if (grp_wr) begin
        base_q <= base_n & amask(ctrl_n[6:4]);
        ctrl_q <= ctrl_n;
      end
      if (cfg_wr && cfg_addr == 8'h91) t1_q <= cfg_wdata;
      if (cfg_wr && cfg_addr == 8'h92) t2_q <= cfg_wdata;
      if (cfg_wr && cfg_addr == 8'h93) t3_q <= cfg_wdata;
    end
  end

  always_comb begin
    case (cfg_addr)
      8'h12:   cfg_rdata = {base_q[1:0], 6'b0};
      8'h13:   cfg_rdata = base_q[BW-1:2];
      8'h91:   cfg_rdata = t1_q;
      8'h92:   cfg_rdata = t2_q;
      8'h93:   cfg_rdata = t3_q;
      8'h94:   cfg_rdata = ctrl_q;
      default: cfg_rdata = 8'h00;
    endcase
  end

  assign win_base  = {base_q, {MIN_LOG{1'b0}}};
  assign win_size  = (int'(ctrl_q[6:4]) >= NCODE) ? '0
                   : (AW'(1) << (MIN_LOG + int'(ctrl_q[6:4])));
  assign win_flag  = ctrl_q[1];
  assign tbl_base  = ctrl_q[0] ? {t3_q, t2_q, t1_q, 8'h00} : '0;
  assign probe_hit = (int'(ctrl_q[6:4]) < NCODE) &&
                     ((probe_addr[AW-1:MIN_LOG] & amask(ctrl_q[6:4])) == base_q);

  // R7
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_size != '0) |-> ((win_base & (win_size - AW'(1))) == '0));

  // R8
  hit_needs_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> (win_size != '0));

  // R5
  flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 8'h94) |=> (win_flag == $past(cfg_wdata[1])));

  // R6
  tbl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 8'h94 && !cfg_wdata[0]) |=> (tbl_base == '0));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_wr && $past(rst_n)) |=> ($stable(win_base) && $stable(win_size) && $stable(tbl_base)));
endmodule

// File: tb/tb_gfx_aperture_cfg.sv
module tb_gfx_aperture_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [31:0] win_base, win_size, tbl_base, probe_addr = 32'h0;
  logic        win_flag, probe_hit;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  gfx_aperture_cfg dut (.*);

  // {write addr, write data, read addr, expected read}
  localparam logic [31:0] VEC [12] = '{
    32'h13AB13AB, // R2
    32'h12FF12C0, // R2
    32'h10551000, // R2
    32'h94FF947F, // R4
    32'h117713AB, // R7 code 7 leaves base bits
    32'h94121280, // R7 8MB clears bit 22
    32'h12C01280, // R7 realign on base write
    32'h946213A0, // R7 256MB
    32'h940213A0, // R7 cleared bits stay cleared
    32'h91349134, // R6
    32'h50995000, // R9
    32'h93789378  // R6
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic exp);
    probe_addr = a;
    #1;
    chk(req, {31'h0, probe_hit}, {31'h0, exp});
  endtask

  task automatic reset_check();
    chk("R1 base", win_base, 32'h0);
    chk("R1 size", win_size, 32'h0040_0000);
    chk("R1 flag", {31'h0, win_flag}, 32'h0);
    chk("R1 tbl", tbl_base, 32'h0);
    rd("R1 rd13", 8'h13, 8'h00);
    rd("R1 rd94", 8'h94, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    foreach (VEC[i]) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      rd($sformatf("R2/R4/R6/R7/R9 vec%0d", i), VEC[i][15:8], VEC[i][7:0]);
    end

    for (int c = 0; c < 8; c++) begin
      wr(8'h94, 8'(c << 4));
      chk($sformatf("R3 code%0d", c), win_size, (c == 7) ? 32'h0 : (32'h0040_0000 << c));
    end

    wr(8'h94, 8'h02);
    chk("R5 flag on", {31'h0, win_flag}, 32'h1);
    wr(8'h94, 8'h00);
    chk("R5 flag off", {31'h0, win_flag}, 32'h0);

    wr(8'h92, 8'h56);
    wr(8'h94, 8'h01);
    chk("R6 tbl on", tbl_base, 32'h7856_3400);
    wr(8'h94, 8'h00);
    chk("R6 tbl off", tbl_base, 32'h0);
    rd("R6 byte kept", 8'h92, 8'h56);

    chk("R7 base", win_base, 32'hA000_0000);
    probe("R8 first", 32'hA000_0000, 1'b1);
    probe("R8 last", 32'hA03F_FFFF, 1'b1);
    probe("R8 past", 32'hA040_0000, 1'b0);
    probe("R8 below", 32'h9FFF_FFFF, 1'b0);
    wr(8'h94, 8'h70);
    probe("R8 disabled", 32'hA000_0000, 1'b0);
    wr(8'h10, 8'hFF);
    chk("R2 low byte write", win_base, 32'hA000_0000);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    reset_check();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule